// File: doc/BRIEF.md
# RV32I Decode Control Generator

This block is the purely combinational decode stage of a single-cycle RV32I core. It accepts one 32-bit instruction word. From that word it produces every control and data field that the rest of the datapath needs to execute the instruction:

- the select for each of the two ALU operands;
- the data-memory read and write enables;
- the register-file write enable and the three-way write-back source select;
- the register indices;
- the immediate, sign-extended according to the instruction's format;
- a small set of flow-control flags that tell the execute stage how to form a jump target.

The block recognises register-register ALU, register-immediate ALU, load, store, conditional branch, lui, auipc, jal and jalr. Any other opcode, including the system and CSR group, leaves every enable low. Such an instruction passes through the core as a no-op. The ALU, the branch comparator, the target adder, fetch and memory sit outside this block and consume its outputs in the same cycle.

Top module: `rvd_decode_top`

## Requirements
- R1: The opcode is instruction bits [6:0]. Recognised values: 0110011 (register ALU), 0010011 (immediate ALU), 0000011 (load), 0100011 (store), 1100011 (branch), 0110111 (lui), 0010111 (auipc), 1101111 (jal), 1100111 (jalr). Any other value, including 1110011 (system/CSR), drives every output to zero.
- R2: `op1_pc_o` (1 = instruction address, 0 = rs1 value) is 1 for auipc and jal, and 0 for all other instructions.
- R3: `op2_imm_o` (1 = immediate, 0 = rs2 value) is 1 for immediate ALU, load, store, lui, auipc, jal and jalr. It is 0 for register ALU and branch.
- R4: `mem_rd_o` is 1 only for loads.
- R5: `mem_wr_o` is 1 only for stores.
- R6: `rf_wr_o` is 1 for register ALU, immediate ALU, load, lui, auipc, jal and jalr, and 0 otherwise.
- R7: `wb_sel_o` is 2'b01 (memory data) for loads and 2'b10 (instruction address + 4) for jal and jalr. It is 2'b00 (ALU result) for every other instruction, and the value 2'b11 never appears.
- R8: `imm_o` follows the instruction's format, and every non-zero format is sign-extended from bit 31:
  - I format (immediate ALU, load, jalr): {bits[31:20]}.
  - S format (store): {bits[31:25], bits[11:7]}.
  - B format (branch): {bit31, bit7, bits[30:25], bits[11:8], 0}.
  - U format (lui, auipc): {bits[31:12], 12 zeros}.
  - J format (jal): {bit31, bits[19:12], bit20, bits[30:21], 0}.
- R9: For lui, `rs1_o` is 0 and `op1_pc_o` is 0, so the ALU adds x0 to the immediate. For auipc and jal, `rs1_o` is also 0.
- R10: `rs1_o` is bits [19:15] for register ALU, immediate ALU, load, store, branch and jalr. `rs2_o` is bits [24:20] for register ALU, store and branch, and 0 otherwise. `rd_o` is bits [11:7] whenever `rf_wr_o` is 1, and 0 otherwise.
- R11: `branch_o` is 1 for branch instructions. `jump_o` is 1 for jal and jalr. `tgt_rs1_o` is 1 only for jalr, where the target base is rs1; for jal and branches the base is the instruction address.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| instr_i | input | 32 | Instruction word to decode |
| op1_pc_o | output | 1 | ALU operand 1: 1 = instruction address, 0 = rs1 value |
| op2_imm_o | output | 1 | ALU operand 2: 1 = immediate, 0 = rs2 value |
| mem_rd_o | output | 1 | Data memory read enable |
| mem_wr_o | output | 1 | Data memory write enable |
| rf_wr_o | output | 1 | Register file write enable |
| wb_sel_o | output | 2 | Write-back source: 00 ALU, 01 memory, 10 PC+4 |
| rs1_o | output | 5 | First source register index |
| rs2_o | output | 5 | Second source register index |
| rd_o | output | 5 | Destination register index |
| imm_o | output | 32 | Sign-extended immediate |
| branch_o | output | 1 | Conditional branch instruction |
| jump_o | output | 1 | Unconditional jump (jal or jalr) |
| tgt_rs1_o | output | 1 | Jump target base: 1 = rs1, 0 = instruction address |

## Verification
The in-RTL assertions check, for every instruction word presented, the relations that hold across the whole decode space:
- the memory enables are never both high;
- loads always write back memory data;
- stores never write the register file;
- the reserved write-back code never appears;
- branch and jal immediates are always even;
- every produced immediate carries instruction bit 31 as its sign;
- a disabled write forces the destination index to zero.

The exact per-opcode values can only be shown by the bench's scenarios, which compare every output against an independent model across random and hand-picked words. These values include each operand select, each immediate bit scatter, and the no-op result for system and malformed opcodes.

// File: rtl/rvd_pkg.sv
package rvd_pkg;

    localparam int ILEN      = 32;
    localparam int OPC_W     = 7;
    localparam int RIDX_W    = 5;
    localparam int WB_W      = 2;
    localparam int U_SHIFT   = 12;

    localparam int RD_LSB    = 7;
    localparam int RS1_LSB   = 15;
    localparam int RS2_LSB   = 20;

    typedef logic [ILEN-1:0]   word_t;
    typedef logic [RIDX_W-1:0] ridx_t;

    typedef enum logic [OPC_W-1:0] {
        OPC_REG    = 7'b0110011,
        OPC_IMM    = 7'b0010011,
        OPC_LOAD   = 7'b0000011,
        OPC_STORE  = 7'b0100011,
        OPC_BRANCH = 7'b1100011,
        OPC_LUI    = 7'b0110111,
        OPC_AUIPC  = 7'b0010111,
        OPC_JAL    = 7'b1101111,
        OPC_JALR   = 7'b1100111
    } opcode_e;

    typedef enum logic [3:0] {
        CLS_NONE,
        CLS_REG,
        CLS_IMM,
        CLS_LOAD,
        CLS_STORE,
        CLS_BRANCH,
        CLS_LUI,
        CLS_AUIPC,
        CLS_JAL,
        CLS_JALR
    } iclass_e;

    typedef enum logic [WB_W-1:0] {
        WB_ALU  = 2'b00,
        WB_MEM  = 2'b01,
        WB_LINK = 2'b10
    } wb_sel_e;

    typedef enum logic {
        OP1_RS1 = 1'b0,
        OP1_PC  = 1'b1
    } op1_sel_e;

    typedef enum logic {
        OP2_RS2 = 1'b0,
        OP2_IMM = 1'b1
    } op2_sel_e;

    typedef enum logic [2:0] {
        FMT_NONE,
        FMT_I,
        FMT_S,
        FMT_B,
        FMT_U,
        FMT_J
    } imm_fmt_e;

    typedef struct packed {
        op1_sel_e op1;
        op2_sel_e op2;
        logic     mem_rd;
        logic     mem_wr;
        logic     rf_wr;
        wb_sel_e  wb;
        imm_fmt_e fmt;
        logic     use_rs1;
        logic     use_rs2;
        logic     branch;
        logic     jump;
        logic     tgt_rs1;
    } ctrl_t;

    localparam ctrl_t CTRL_NOP = '{
        op1:     OP1_RS1,
        op2:     OP2_RS2,
        mem_rd:  1'b0,
        mem_wr:  1'b0,
        rf_wr:   1'b0,
        wb:      WB_ALU,
        fmt:     FMT_NONE,
        use_rs1: 1'b0,
        use_rs2: 1'b0,
        branch:  1'b0,
        jump:    1'b0,
        tgt_rs1: 1'b0
    };

    function automatic word_t sext_imm_i(input word_t w);
        return {{(ILEN-12){w[31]}}, w[31:20]};
    endfunction

    function automatic word_t sext_imm_s(input word_t w);
        return {{(ILEN-12){w[31]}}, w[31:25], w[11:7]};
    endfunction

    function automatic word_t sext_imm_b(input word_t w);
        return {{(ILEN-13){w[31]}}, w[31], w[7], w[30:25], w[11:8], 1'b0};
    endfunction

    function automatic word_t sext_imm_u(input word_t w);
        return {w[31:U_SHIFT], {U_SHIFT{1'b0}}};
    endfunction

    function automatic word_t sext_imm_j(input word_t w);
        return {{(ILEN-21){w[31]}}, w[31], w[19:12], w[20], w[30:21], 1'b0};
    endfunction

    function automatic ridx_t field_idx(input word_t w, input int lsb);
        return w[lsb +: RIDX_W];
    endfunction

endpackage

// File: rtl/rvd_classify.sv
module rvd_classify
    import rvd_pkg::*;
(
    input  logic [ILEN-1:0] instr_i,
    output iclass_e         cls_o
);

    logic [OPC_W-1:0] opc;
    assign opc = instr_i[OPC_W-1:0];

    always_comb begin
        cls_o = CLS_NONE;
        unique case (opc)
            OPC_REG:    cls_o = CLS_REG;
            OPC_IMM:    cls_o = CLS_IMM;
            OPC_LOAD:   cls_o = CLS_LOAD;
            OPC_STORE:  cls_o = CLS_STORE;
            OPC_BRANCH: cls_o = CLS_BRANCH;
            OPC_LUI:    cls_o = CLS_LUI;
            OPC_AUIPC:  cls_o = CLS_AUIPC;
            OPC_JAL:    cls_o = CLS_JAL;
            OPC_JALR:   cls_o = CLS_JALR;
            default:    cls_o = CLS_NONE;
        endcase
    end

endmodule

// File: rtl/rvd_ctrl_table.sv
module rvd_ctrl_table
    import rvd_pkg::*;
(
    input  iclass_e cls_i,
    output ctrl_t   ctrl_o
);

    always_comb begin
        ctrl_o = CTRL_NOP;
        case (cls_i)
            CLS_REG: begin
                ctrl_o.rf_wr   = 1'b1;
                ctrl_o.use_rs1 = 1'b1;
                ctrl_o.use_rs2 = 1'b1;
            end
            CLS_IMM: begin
                ctrl_o.op2     = OP2_IMM;
                ctrl_o.rf_wr   = 1'b1;
                ctrl_o.fmt     = FMT_I;
                ctrl_o.use_rs1 = 1'b1;
            end
            CLS_LOAD: begin
                ctrl_o.op2     = OP2_IMM;
                ctrl_o.mem_rd  = 1'b1;
                ctrl_o.rf_wr   = 1'b1;
                ctrl_o.wb      = WB_MEM;
                ctrl_o.fmt     = FMT_I;
                ctrl_o.use_rs1 = 1'b1;
            end
            CLS_STORE: begin
                ctrl_o.op2     = OP2_IMM;
                ctrl_o.mem_wr  = 1'b1;
                ctrl_o.fmt     = FMT_S;
                ctrl_o.use_rs1 = 1'b1;
                ctrl_o.use_rs2 = 1'b1;
            end
            CLS_BRANCH: begin
                ctrl_o.fmt     = FMT_B;
                ctrl_o.use_rs1 = 1'b1;
                ctrl_o.use_rs2 = 1'b1;
                ctrl_o.branch  = 1'b1;
            end
            CLS_LUI: begin
                // operand 1 reads index 0, which is the hard-wired zero register
                ctrl_o.op2     = OP2_IMM;
                ctrl_o.rf_wr   = 1'b1;
                ctrl_o.fmt     = FMT_U;
            end
            CLS_AUIPC: begin
                ctrl_o.op1     = OP1_PC;
                ctrl_o.op2     = OP2_IMM;
                ctrl_o.rf_wr   = 1'b1;
                ctrl_o.fmt     = FMT_U;
            end
            CLS_JAL: begin
                ctrl_o.op1     = OP1_PC;
                ctrl_o.op2     = OP2_IMM;
                ctrl_o.rf_wr   = 1'b1;
                ctrl_o.wb      = WB_LINK;
                ctrl_o.fmt     = FMT_J;
                ctrl_o.jump    = 1'b1;
            end
            CLS_JALR: begin
                ctrl_o.op2     = OP2_IMM;
                ctrl_o.rf_wr   = 1'b1;
                ctrl_o.wb      = WB_LINK;
                ctrl_o.fmt     = FMT_I;
                ctrl_o.use_rs1 = 1'b1;
                ctrl_o.jump    = 1'b1;
                ctrl_o.tgt_rs1 = 1'b1;
            end
            default: ctrl_o = CTRL_NOP;
        endcase
    end

endmodule

// File: rtl/rvd_imm_gen.sv
module rvd_imm_gen
    import rvd_pkg::*;
(
    input  logic [ILEN-1:0] instr_i,
    input  imm_fmt_e        fmt_i,
    output logic [ILEN-1:0] imm_o
);

    localparam int NFMT = 6;

    word_t cand [NFMT];

    // one candidate per format, selected by the decoded format code
    for (genvar f = 0; f < NFMT; f++) begin : g_fmt
        if (f == int'(FMT_I)) begin : g_i
            assign cand[f] = sext_imm_i(instr_i);
        end else if (f == int'(FMT_S)) begin : g_s
            assign cand[f] = sext_imm_s(instr_i);
        end else if (f == int'(FMT_B)) begin : g_b
            assign cand[f] = sext_imm_b(instr_i);
        end else if (f == int'(FMT_U)) begin : g_u
            assign cand[f] = sext_imm_u(instr_i);
        end else if (f == int'(FMT_J)) begin : g_j
            assign cand[f] = sext_imm_j(instr_i);
        end else begin : g_none
            assign cand[f] = '0;
        end
    end

    always_comb begin
        imm_o = '0;
        if (int'(fmt_i) < NFMT) begin
            imm_o = cand[int'(fmt_i)];
        end
    end

    always_comb begin
        AST_IMM_SIGN: assert ((fmt_i == FMT_NONE) || (imm_o[ILEN-1] == instr_i[ILEN-1]))
            else $error("immediate sign differs from instruction bit 31"); // R8
    end

endmodule

// File: rtl/rvd_regidx.sv
module rvd_regidx
    import rvd_pkg::*;
(
    input  logic [ILEN-1:0]   instr_i,
    input  ctrl_t             ctrl_i,
    output logic [RIDX_W-1:0] rs1_o,
    output logic [RIDX_W-1:0] rs2_o,
    output logic [RIDX_W-1:0] rd_o
);

    assign rs1_o = ctrl_i.use_rs1 ? field_idx(instr_i, RS1_LSB) : '0;
    assign rs2_o = ctrl_i.use_rs2 ? field_idx(instr_i, RS2_LSB) : '0;
    assign rd_o  = ctrl_i.rf_wr   ? field_idx(instr_i, RD_LSB)  : '0;

endmodule

// File: rtl/rvd_decode_top.sv
module rvd_decode_top
    import rvd_pkg::*;
(
    input  logic [31:0] instr_i,
    output logic        op1_pc_o,
    output logic        op2_imm_o,
    output logic        mem_rd_o,
    output logic        mem_wr_o,
    output logic        rf_wr_o,
    output logic [1:0]  wb_sel_o,
    output logic [4:0]  rs1_o,
    output logic [4:0]  rs2_o,
    output logic [4:0]  rd_o,
    output logic [31:0] imm_o,
    output logic        branch_o,
    output logic        jump_o,
    output logic        tgt_rs1_o
);

    iclass_e cls;
    ctrl_t   ctrl;

    rvd_classify u_classify (
        .instr_i (instr_i),
        .cls_o   (cls)
    );

    rvd_ctrl_table u_ctrl (
        .cls_i  (cls),
        .ctrl_o (ctrl)
    );

    rvd_imm_gen u_imm (
        .instr_i (instr_i),
        .fmt_i   (ctrl.fmt),
        .imm_o   (imm_o)
    );

    rvd_regidx u_idx (
        .instr_i (instr_i),
        .ctrl_i  (ctrl),
        .rs1_o   (rs1_o),
        .rs2_o   (rs2_o),
        .rd_o    (rd_o)
    );

    assign op1_pc_o  = (ctrl.op1 == OP1_PC);
    assign op2_imm_o = (ctrl.op2 == OP2_IMM);
    assign mem_rd_o  = ctrl.mem_rd;
    assign mem_wr_o  = ctrl.mem_wr;
    assign rf_wr_o   = ctrl.rf_wr;
    assign wb_sel_o  = ctrl.wb;
    assign branch_o  = ctrl.branch;
    assign jump_o    = ctrl.jump;
    assign tgt_rs1_o = ctrl.tgt_rs1;

    always_comb begin
        AST_MEM_EXCL: assert (!(mem_rd_o && mem_wr_o))
            else $error("read and write enables both high"); // R4
        AST_STORE_NO_RF: assert (!mem_wr_o || !rf_wr_o)
            else $error("store writes register file"); // R5
        AST_LOAD_WB_MEM: assert (!mem_rd_o || (rf_wr_o && wb_sel_o == 2'b01))
            else $error("load does not write back memory data"); // R7
        AST_WB_LEGAL: assert (wb_sel_o != 2'b11)
            else $error("reserved write-back code"); // R7
        AST_LINK_JUMP: assert ((wb_sel_o != 2'b10) || jump_o)
            else $error("link write-back without jump"); // R7
        AST_EVEN_OFFSET: assert (!(branch_o || (jump_o && !tgt_rs1_o)) || !imm_o[0])
            else $error("branch or jal offset is odd"); // R8
        AST_RD_ZERO: assert (rf_wr_o || rd_o == '0)
            else $error("destination index without write"); // R10
        AST_TGT_JUMP: assert (!tgt_rs1_o || (jump_o && !op1_pc_o))
            else $error("rs1 target base outside jalr"); // R11
        AST_NOT_BOTH_FLOW: assert (!(branch_o && jump_o))
            else $error("branch and jump both flagged"); // R11
    end

endmodule

// File: tb/rvd_decode_top_tb.sv
module rvd_decode_top_tb;

    logic        clk = 1'b0;
    logic [31:0] instr = 32'h0;
    logic        op1_pc, op2_imm, mem_rd, mem_wr, rf_wr, branch, jump, tgt_rs1;
    logic [1:0]  wb_sel;
    logic [4:0]  rs1, rs2, rd;
    logic [31:0] imm;

    int checks = 0;
    int errors = 0;
    bit done   = 1'b0;

    always #4 clk = ~clk;  // 125 MHz

    rvd_decode_top u_dut (
        .instr_i   (instr),
        .op1_pc_o  (op1_pc),
        .op2_imm_o (op2_imm),
        .mem_rd_o  (mem_rd),
        .mem_wr_o  (mem_wr),
        .rf_wr_o   (rf_wr),
        .wb_sel_o  (wb_sel),
        .rs1_o     (rs1),
        .rs2_o     (rs2),
        .rd_o      (rd),
        .imm_o     (imm),
        .branch_o  (branch),
        .jump_o    (jump),
        .tgt_rs1_o (tgt_rs1)
    );

    task automatic chk(input string tag, input string what, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s instr=%08h actual=%08h expected=%08h", tag, what, instr, act, exp);
        end
    endtask

    // independent model of the requirements
    task automatic model(input logic [31:0] w,
                         output logic e_op1, output logic e_op2, output logic e_mrd,
                         output logic e_mwr, output logic e_rfw, output logic [1:0] e_wb,
                         output logic [4:0] e_rs1, output logic [4:0] e_rs2, output logic [4:0] e_rd,
                         output logic [31:0] e_imm, output logic e_br, output logic e_jmp,
                         output logic e_tgt);
        logic [31:0] ii, is, ib, iu, ij;
        ii = {{20{w[31]}}, w[31:20]};
        is = {{20{w[31]}}, w[31:25], w[11:7]};
        ib = {{19{w[31]}}, w[31], w[7], w[30:25], w[11:8], 1'b0};
        iu = {w[31:12], 12'h000};
        ij = {{11{w[31]}}, w[31], w[19:12], w[20], w[30:21], 1'b0};
        e_op1 = 0; e_op2 = 0; e_mrd = 0; e_mwr = 0; e_rfw = 0; e_wb = 2'b00;
        e_rs1 = 0; e_rs2 = 0; e_imm = 0; e_br = 0; e_jmp = 0; e_tgt = 0;
        case (w[6:0])
            7'b0110011: begin e_rfw = 1; e_rs1 = w[19:15]; e_rs2 = w[24:20]; end
            7'b0010011: begin e_op2 = 1; e_rfw = 1; e_rs1 = w[19:15]; e_imm = ii; end
            7'b0000011: begin e_op2 = 1; e_rfw = 1; e_mrd = 1; e_wb = 2'b01; e_rs1 = w[19:15]; e_imm = ii; end
            7'b0100011: begin e_op2 = 1; e_mwr = 1; e_rs1 = w[19:15]; e_rs2 = w[24:20]; e_imm = is; end
            7'b1100011: begin e_br = 1; e_rs1 = w[19:15]; e_rs2 = w[24:20]; e_imm = ib; end
            7'b0110111: begin e_op2 = 1; e_rfw = 1; e_imm = iu; end
            7'b0010111: begin e_op1 = 1; e_op2 = 1; e_rfw = 1; e_imm = iu; end
            7'b1101111: begin e_op1 = 1; e_op2 = 1; e_rfw = 1; e_wb = 2'b10; e_jmp = 1; e_imm = ij; end
            7'b1100111: begin e_op2 = 1; e_rfw = 1; e_wb = 2'b10; e_jmp = 1; e_tgt = 1; e_rs1 = w[19:15]; e_imm = ii; end
            default: ;
        endcase
        e_rd = e_rfw ? w[11:7] : 5'd0;
    endtask

    task automatic apply(input logic [31:0] w);
        logic e_op1, e_op2, e_mrd, e_mwr, e_rfw, e_br, e_jmp, e_tgt;
        logic [1:0] e_wb;
        logic [4:0] e_rs1, e_rs2, e_rd;
        logic [31:0] e_imm;
        @(negedge clk);
        instr = w;
        #2;
        model(w, e_op1, e_op2, e_mrd, e_mwr, e_rfw, e_wb, e_rs1, e_rs2, e_rd, e_imm, e_br, e_jmp, e_tgt);
        chk("R2",  "op1_pc",  {31'd0, op1_pc},  {31'd0, e_op1});
        chk("R3",  "op2_imm", {31'd0, op2_imm}, {31'd0, e_op2});
        chk("R4",  "mem_rd",  {31'd0, mem_rd},  {31'd0, e_mrd});
        chk("R5",  "mem_wr",  {31'd0, mem_wr},  {31'd0, e_mwr});
        chk("R6",  "rf_wr",   {31'd0, rf_wr},   {31'd0, e_rfw});
        chk("R7",  "wb_sel",  {30'd0, wb_sel},  {30'd0, e_wb});
        chk("R8",  "imm",     imm,              e_imm);
        chk("R10", "rs1",     {27'd0, rs1},     {27'd0, e_rs1});
        chk("R10", "rs2",     {27'd0, rs2},     {27'd0, e_rs2});
        chk("R10", "rd",      {27'd0, rd},      {27'd0, e_rd});
        chk("R11", "branch",  {31'd0, branch},  {31'd0, e_br});
        chk("R11", "jump",    {31'd0, jump},    {31'd0, e_jmp});
        chk("R11", "tgt_rs1", {31'd0, tgt_rs1}, {31'd0, e_tgt});
    endtask

    task automatic all_zero_check(input string tag);
        chk(tag, "any_enable", {26'd0, op1_pc, op2_imm, mem_rd, mem_wr, rf_wr, branch}, 32'd0);
        chk(tag, "flow",       {29'd0, jump, tgt_rs1, 1'b0}, 32'd0);
        chk(tag, "wb_sel",     {30'd0, wb_sel}, 32'd0);
        chk(tag, "imm",        imm, 32'd0);
        chk(tag, "indices",    {17'd0, rs1, rs2, rd}, 32'd0);
    endtask

    localparam logic [6:0] OPS [9] = '{7'b0110011, 7'b0010011, 7'b0000011, 7'b0100011,
                                       7'b1100011, 7'b0110111, 7'b0010111, 7'b1101111,
                                       7'b1100111};

    initial begin
        void'($urandom(32'd20240517));
        repeat (2) @(negedge clk);

        // R1: all-zero word is an unrecognised opcode, every output zero
        apply(32'h0000_0000);
        all_zero_check("R1");
        // R1: system/CSR (csrrw x5, 0x300, x6) decodes with no side effects
        apply(32'h3003_12f3);
        all_zero_check("R1");
        // R1: register opcode with low bits 01 is not recognised
        apply(32'h00b5_0531);
        all_zero_check("R1");

        // R9: lui with a negative upper immediate; rs1 index 0, operand 1 from register
        apply(32'hfffff_5b7);
        chk("R9", "lui_rs1", {27'd0, rs1}, 32'd0);
        chk("R9", "lui_op1", {31'd0, op1_pc}, 32'd0);
        chk("R9", "lui_imm", imm, 32'hffff_f000);
        // R9: auipc takes instruction address, rs1 zero
        apply(32'h1234_5097);
        chk("R9", "auipc_rs1", {27'd0, rs1}, 32'd0);
        chk("R9", "auipc_imm", imm, 32'h1234_5000);

        // R8: jal most negative offset -> 0xfff00000
        apply(32'h8000_00ef);
        chk("R8", "jal_min", imm, 32'hfff0_0000);
        // R8: branch all offset bits set -> -2
        apply(32'hfe00_0fe3);
        chk("R8", "beq_m2", imm, 32'hffff_fffe);
        // R8: store with imm 0x7ff
        apply(32'h7e00_afa3);
        chk("R8", "sw_max", imm, 32'h0000_07ff);
        // R11: jalr target base rs1
        apply(32'hffc2_8067);
        chk("R11", "jalr_tgt", {31'd0, tgt_rs1}, 32'd1);
        chk("R7",  "jalr_wb",  {30'd0, wb_sel}, 32'd2);

        // random stimulus over recognised and unrecognised opcodes
        for (int n = 0; n < 3000; n++) begin
            logic [31:0] w;
            int sel;
            w = $urandom;
            sel = int'($urandom % 12);
            if (sel < 9) w[6:0] = OPS[sel];
            else if (sel == 9) w[6:0] = 7'b1110011;
            apply(w);
        end

        done = 1'b1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog expired");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

endmodule